// File: doc/BRIEF.md
# Serial Recirculating Loop Bank with Shared Access Port

The block holds a bank of serial storage loops. Every loop is a ring of a fixed number of bits that advances one position per clock, so each stored bit passes the loop head once per revolution. Each loop has a switching gate. While the gate is off, the bit leaving the loop head is fed straight back into the loop tail. While the gate is on, the bit goes out on a bus shared by all gates, and the loop tail takes its bit from a second shared bus.

A single shared network sits between the two buses and the controller. In read mode it loops the output bus back onto the input bus, so the bit keeps circulating and a copy reaches the controller. In write mode it cuts the output bus off and drives the controller's serial write data onto the input bus, so the old bit is replaced. The gate therefore needs only one on state. The off path is padded to the same three clocks as the on path, so the revolution time of a loop does not depend on whether or when it was selected.

The controller presents a one-hot select (address decoding is done elsewhere) together with the mode and write bit. A loop is read or written one bit per cycle by holding its select for as many cycles as the bits it wants, in step with the loop rotation.

Top module: `dlm_bank`

## Requirements
- R1: After reset every bit of every loop is 0, and so is rdata_o.
- R2: Each loop has a period of exactly LOOP_BITS clocks: a bit at the loop head in cycle c is at the head again in cycle c+LOOP_BITS, whether or not the loop was selected in between.
- R3: In read mode (write_i = 0), with sel_i[k] = 1 in cycle c, rdata_o in cycle c+1 equals the bit at the head of loop k in cycle c, and that bit stays in the loop unchanged.
- R4: In write mode (write_i = 1), with sel_i[k] = 1 in cycle c, the bit at the head of loop k in cycle c is replaced by wdata_i of cycle c, and rdata_o in cycle c+1 is 0.
- R5: A loop whose select bit is 0 keeps its contents, whatever is read from or written to other loops.
- R6: When no select bit is set in cycle c, rdata_o in cycle c+1 is 0 and wdata_i has no effect on any loop.
- R7: Select may move from one loop to another, or toggle on and off, in consecutive cycles without loss or corruption of any bit; at most one select bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all loops and stages |
| sel_i | input | NUM_LOOPS | One-hot (or zero) loop select |
| write_i | input | 1 | 0 = read mode, 1 = write mode |
| wdata_i | input | 1 | Serial write bit, used in write mode |
| rdata_o | output | 1 | Serial read bit, one cycle after the select |

## Verification
The two functions that meet in one cycle are a loop coming off the bus while another loop goes onto it: the first loop's bit is still inside the three-stage bus path when the second loop's bit enters it, and the first loop's own bypass resumes while its bus bit is still returning. Random traffic with a fresh one-hot select or none in each cycle, with random mode and write bits, provokes this constantly, and a directed toggle pattern repeats it on a single loop. A bench model of every ring, indexed by cycle modulo the loop length, predicts rdata_o one cycle after each selection, and full-revolution reads of every loop afterwards show whether any bit was lost or shifted.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  // Clocks from loop head back to loop tail, on either path.
  localparam int unsigned GATE_LAT = 3;

  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_WRITE = 1'b1
  } dlm_mode_e;
endpackage

// File: rtl/dlm_line.sv
module dlm_line #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tail_i,
  output logic head_o
);
  generate
    if (DEPTH == 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= tail_i;
      end
      assign head_o = q;
    end else begin : g_shift
      logic [DEPTH-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[DEPTH-2:0], tail_i};
      end
      assign head_o = q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dlm_gate.sv
module dlm_gate
  import dlm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic head_i,
  input  logic in_bus_i,
  output logic bus_o,
  output logic tail_o
);
  logic [GATE_LAT-1:0] byp_q;
  logic [GATE_LAT-2:0] sel_d;
  logic                out_q;
  logic                in_q;

  // Off path: padded to GATE_LAT so ring timing is select-independent.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= '0;
      sel_d <= '0;
      out_q <= 1'b0;
      in_q  <= 1'b0;
    end else begin
      byp_q <= {byp_q[GATE_LAT-2:0], head_i & ~sel_i};
      sel_d <= {sel_d[GATE_LAT-3:0], sel_i};
      out_q <= head_i & sel_i;
      // accept the return bit that belongs to the cycle this gate was on
      in_q  <= in_bus_i & sel_d[GATE_LAT-2];
    end
  end

  assign bus_o  = out_q;
  assign tail_o = byp_q[GATE_LAT-1] | in_q;

  p_off_path_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i, 3) |-> (tail_o == $past(head_i, 3)));

  p_bus_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i) |-> !bus_o);
endmodule

// File: rtl/dlm_bus_net.sv
module dlm_bus_net
  import dlm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_bus_i,
  input  logic write_i,
  input  logic wdata_i,
  output logic in_bus_o,
  output logic rdata_o
);
  dlm_mode_e mode_q;
  logic      wdata_q;
  logic      in_bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_READ;
      wdata_q  <= 1'b0;
      in_bus_q <= 1'b0;
    end else begin
      mode_q   <= write_i ? MODE_WRITE : MODE_READ;
      wdata_q  <= wdata_i;
      in_bus_q <= (mode_q == MODE_WRITE) ? wdata_q : out_bus_i;
    end
  end

  assign in_bus_o = in_bus_q;
  assign rdata_o  = (mode_q == MODE_READ) & out_bus_i;

  p_loopback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(write_i, 2) |-> (in_bus_o == $past(out_bus_i)));

  p_write_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(write_i, 2) |-> (in_bus_o == $past(wdata_i, 2)));

  p_write_isolated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(write_i) |-> !rdata_o);
endmodule

// File: rtl/dlm_bank.sv
module dlm_bank
  import dlm_pkg::*;
#(
  parameter int unsigned NUM_LOOPS = 256,
  parameter int unsigned LOOP_BITS = 1024
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LOOPS-1:0] sel_i,
  input  logic                 write_i,
  input  logic                 wdata_i,
  output logic                 rdata_o
);
  localparam int unsigned LINE_DEPTH = LOOP_BITS - GATE_LAT;

  logic [NUM_LOOPS-1:0] bus_vec;
  logic                 out_bus;
  logic                 in_bus;

  generate
    for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_loop
      logic head;
      logic tail;

      dlm_line #(.DEPTH(LINE_DEPTH)) i_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tail_i (tail),
        .head_o (head)
      );

      dlm_gate i_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (sel_i[k]),
        .head_i   (head),
        .in_bus_i (in_bus),
        .bus_o    (bus_vec[k]),
        .tail_o   (tail)
      );
    end
  endgenerate

  assign out_bus = |bus_vec;

  dlm_bus_net i_net (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .out_bus_i (out_bus),
    .write_i   (write_i),
    .wdata_i   (wdata_i),
    .in_bus_o  (in_bus),
    .rdata_o   (rdata_o)
  );

  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));

  p_bus_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_vec));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel_i) == '0) |-> !rdata_o);
endmodule

// File: tb/test_dlm_bank.sv
module test_dlm_bank;
  localparam int unsigned N      = 8;
  localparam int unsigned L      = 16;
  localparam time         CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] sel_i = '0;
  logic         write_i = 1'b0;
  logic         wdata_i = 1'b0;
  logic         rdata_o;

  int n_vec = 0;
  int n_bad = 0;
  int unsigned cyc = 0;
  logic ring [N][L];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dlm_bank #(.NUM_LOOPS(N), .LOOP_BITS(L)) i_dlm_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .write_i (write_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  function automatic logic exp_rdata(input int sel_idx, input logic wr, input int unsigned c);
    if (sel_idx < 0 || wr) return 1'b0;
    return ring[sel_idx][c % L];
  endfunction

  // One clock: drive at negedge, model updates at posedge, check at next negedge.
  task automatic step(input int sel_idx, input logic wr, input logic wd, input string req);
    logic e;
    sel_i   = (sel_idx >= 0) ? (N'(1) << sel_idx) : '0;
    write_i = wr;
    wdata_i = wd;
    @(posedge clk_i);
    e = exp_rdata(sel_idx, wr, cyc);
    if (sel_idx >= 0 && wr) ring[sel_idx][cyc % L] = wd;
    cyc++;
    @(negedge clk_i);
    n_vec++;
    if (rdata_o !== e) begin
      n_bad++;
      $display("FAIL %s cyc=%0d sel=%0d wr=%0b rdata actual=%0b expected=%0b",
               req, cyc, sel_idx, wr, rdata_o, e);
    end
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < N; k++)
      for (int b = 0; b < L; b++) step(k, 1'b0, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++)
      for (int b = 0; b < L; b++) ring[k][b] = 1'b0;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: everything reads 0 after reset
    read_all("R1");

    // R4: write a known pattern into loop 3, rdata stays 0 while writing
    for (int b = 0; b < L; b++) step(3, 1'b1, logic'((b * 5 + 1) % 3 == 0), "R4");

    // R3/R2: read back over two revolutions; bits stay in place
    for (int b = 0; b < 2 * L; b++) step(3, 1'b0, 1'b1, (b < L) ? "R3" : "R2");

    // R5: other loops untouched
    for (int k = 0; k < N; k++)
      if (k != 3) for (int b = 0; b < L; b++) step(k, 1'b0, 1'b0, "R5");

    // R6: idle with noisy write data, nothing read, nothing written
    for (int b = 0; b < 2 * L; b++) step(-1, logic'($urandom % 2), logic'($urandom % 2), "R6");

    // R2: single bit into loop 1, idle until it comes round again
    step(1, 1'b1, 1'b1, "R2");
    for (int b = 0; b < L - 1; b++) step(-1, 1'b0, 1'b0, "R2");
    step(1, 1'b0, 1'b0, "R2");

    // R7: toggle loop 5 on and off every cycle while writing, then verify
    for (int b = 0; b < 4 * L; b++)
      step((b % 2 == 0) ? 5 : -1, 1'b1, logic'($urandom % 2), "R7");
    for (int b = 0; b < L; b++) step(5, 1'b0, 1'b0, "R7");

    // R7: back-to-back hand-over between neighbouring loops
    for (int b = 0; b < 4 * L; b++) step(b % N, logic'(b % 3 == 0), logic'($urandom % 2), "R7");

    // R7/R3/R4/R5: random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom % (N + 2);
      step((r < N) ? int'(r) : -1, logic'($urandom % 2), logic'($urandom % 2), "R7");
    end

    // R5/R2: final full sweep of every loop against the model
    read_all("R5");
    read_all("R2");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule